// File: doc/BRIEF.md
# NAND Flash Host Bus Bridge

This block connects a 16-bit host register bus to an 8-bit raw NAND flash device. The host selects how the next data access behaves by writing a byte-wide code into a mode register. That code drives the chip-enable, command-latch and address-latch lines. A later access to the data register then becomes a command byte, an address byte or one or two data bytes. A 16-bit data access moves two flash bytes back to back, low byte first. An 8-bit data access moves a single byte, which is the path used for command and address bytes.

The flash ready/busy line is brought into the clock domain through a flop chain. Its level appears as a busy flag in a status register. Its rising edge (busy released) latches a pending ready event. The host reads that event and clears it by writing ones. A mask register gates the event onto a registered interrupt output. While the byte cycles of a data access are in progress, the host bus is stalled with a request/acknowledge handshake.

Top module: `nand_host_bridge`

## Requirements
- R1: After reset, chip-enable is inactive (`nf_ce_n`=1), `nf_cle`=0, `nf_ale`=0, both strobes are high, `nf_dq_oe`=0, and both `irq` and `hb_ack` are 0.
- R2: The mode register sits at offset 4 and reads back what was written. Bit 4 asserts chip-enable, bit 0 drives `nf_cle` and bit 1 drives `nf_ale`. So 0x95 selects command cycles, 0x96 selects address cycles, 0x94 selects plain data cycles, and 0x00 releases chip-enable.
- R3: An 8-bit write to the data register (offset 0, `hb_wide`=0) performs exactly one flash write cycle carrying `hb_wdata[7:0]`. The latch lines during that cycle are the ones set by the mode register.
- R4: A 16-bit write to the data register performs two flash write cycles: `hb_wdata[7:0]` first, then `hb_wdata[15:8]`.
- R5: A 16-bit read of the data register performs two flash read cycles and returns the first byte in `hb_rdata[7:0]` and the second in `hb_rdata[15:8]`. An 8-bit read performs one cycle and returns zero in `hb_rdata[15:8]`.
- R6: Each write strobe and each read strobe stays low for exactly STROBE_CLKS clocks. The data bus is driven during the clock before a write strobe falls and is not driven while a read strobe is low. The two strobes are never low together.
- R7: A register access is acknowledged on the first clock edge after the request. A data access is acknowledged (SETUP_CLKS+STROBE_CLKS+1) clock edges per byte after acceptance. `hb_ack` stays low while byte cycles are in progress.
- R8: Status bit 7 (offset 5) reads 1 while `nf_rb_n` is low, after the synchroniser delay.
- R9: Pending bit 0 (offset 6) is set by a rising edge of the synchronised ready/busy line. Writing 1 to bit 0 clears it (0x0F clears all pending bits). A new event in the same cycle as a clear wins.
- R10: The mask register sits at offset 7. `irq` is registered and equals mask bit 7 AND mask bit 0 AND the pending bit, so writing 0x81 enables the ready interrupt. With either mask bit clear, `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_req | input | 1 | Host request, held until `hb_ack` |
| hb_wr | input | 1 | 1 = write, 0 = read |
| hb_wide | input | 1 | 1 = full-width data access, 0 = single byte |
| hb_addr | input | 3 | Register offset |
| hb_wdata | input | HOST_W | Write data |
| hb_rdata | output | HOST_W | Read data, valid with `hb_ack` |
| hb_ack | output | 1 | One-cycle completion pulse |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Flash data out |
| nf_dq_oe | output | 1 | Flash data output enable |
| nf_dq_in | input | 8 | Flash data in |
| nf_rb_n | input | 1 | Flash ready (1) / busy (0) |
| irq | output | 1 | Ready interrupt |

## Verification
The bench builds the bridge with SETUP_CLKS=2 and STROBE_CLKS=3 rather than the defaults. Both the set-up and strobe counters therefore run through several values, and an off-by-one in either phase changes the measured strobe width and the acknowledge latency. HOST_W stays at 16 and SYNC_STAGES at 2. Under those values the two-byte packing order, and the exact cycle on which a released busy line reaches the pending bit and then the interrupt, can be compared against the reference model on every clock.

// File: rtl/nhb_pkg.sv
package nhb_pkg;

  // register offsets on the host side
  localparam logic [2:0] OFS_DATA     = 3'h0;
  localparam logic [2:0] OFS_MODE     = 3'h4;
  localparam logic [2:0] OFS_STAT     = 3'h5;
  localparam logic [2:0] OFS_IRQ_PEND = 3'h6;
  localparam logic [2:0] OFS_IRQ_MASK = 3'h7;

  // mode register bit positions decoded by the pin logic
  localparam int unsigned MODE_CLE = 0;
  localparam int unsigned MODE_ALE = 1;
  localparam int unsigned MODE_CE  = 4;

  // status and mask bit positions
  localparam int unsigned STAT_BUSY   = 7;
  localparam int unsigned MASK_GLOBAL = 7;
  localparam int unsigned MASK_READY  = 0;

  typedef enum logic [1:0] {
    CYC_IDLE,
    CYC_SETUP,
    CYC_STROBE,
    CYC_HOLD
  } cyc_phase_e;

  typedef enum logic {
    HOST_IDLE,
    HOST_XFER
  } host_state_e;

endpackage

// File: rtl/nhb_rb_sync.sv
module nhb_rb_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_n_async,
  output logic rb_ready,
  output logic rb_rise
);

  logic [SYNC_STAGES-1:0] stg_q;
  logic [SYNC_STAGES-1:0] stg_d;
  logic                   last_q;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        assign stg_d[gi] = rb_n_async;
      end else begin : g_chain
        assign stg_d[gi] = stg_q[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '1;
      last_q <= 1'b1;
    end else begin
      stg_q  <= stg_d;
      last_q <= stg_q[SYNC_STAGES-1];
    end
  end

  assign rb_ready = stg_q[SYNC_STAGES-1];
  assign rb_rise  = stg_q[SYNC_STAGES-1] & ~last_q;

  // an edge pulse lasts one cycle only
  assert_rise_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rb_rise |=> !rb_rise);

endmodule

// File: rtl/nhb_irq_ctrl.sv
module nhb_irq_ctrl
  import nhb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ready_evt,
  input  logic       pend_clr,
  input  logic       mask_we,
  input  logic [7:0] mask_wdata,
  output logic       pend,
  output logic [7:0] mask,
  output logic       irq
);

  logic       pend_q, pend_d;
  logic [7:0] mask_q, mask_d;
  logic       irq_q, irq_d;

  always_comb begin
    pend_d = ready_evt | (pend_q & ~pend_clr);
    mask_d = mask_we ? mask_wdata : mask_q;
    irq_d  = mask_q[MASK_GLOBAL] & mask_q[MASK_READY] & pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
      irq_q  <= irq_d;
    end
  end

  assign pend = pend_q;
  assign mask = mask_q;
  assign irq  = irq_q;

  assert_event_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ready_evt |=> pend_q);

  assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && !ready_evt) |=> !pend_q);

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q[MASK_GLOBAL] |=> !irq_q);

endmodule

// File: rtl/nhb_byte_cycle.sv
module nhb_byte_cycle
  import nhb_pkg::*;
#(
  parameter int unsigned SETUP_CLKS  = 1,
  parameter int unsigned STROBE_CLKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rd,
  input  logic [7:0] wbyte,
  input  logic [7:0] dq_in,
  output logic       last,
  output logic [7:0] rbyte,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] dq_out,
  output logic       dq_oe
);

  localparam int unsigned CNT_MAX = (SETUP_CLKS > STROBE_CLKS) ? SETUP_CLKS : STROBE_CLKS;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  cyc_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rd_q, rd_d;
  logic [7:0]       dq_q, dq_d;
  logic             oe_q, oe_d;
  logic             we_n_q, we_n_d;
  logic             re_n_q, re_n_d;
  logic [7:0]       rbyte_q, rbyte_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    rd_d    = rd_q;
    dq_d    = dq_q;
    oe_d    = oe_q;
    we_n_d  = we_n_q;
    re_n_d  = re_n_q;
    rbyte_d = rbyte_q;
    case (phase_q)
      CYC_IDLE, CYC_HOLD: begin
        if (start) begin
          phase_d = CYC_SETUP;
          cnt_d   = CNT_W'(SETUP_CLKS - 1);
          rd_d    = rd;
          dq_d    = wbyte;
          oe_d    = ~rd;
        end else if (phase_q == CYC_HOLD) begin
          phase_d = CYC_IDLE;
          oe_d    = 1'b0;
        end
      end
      CYC_SETUP: begin
        if (cnt_q == '0) begin
          phase_d = CYC_STROBE;
          cnt_d   = CNT_W'(STROBE_CLKS - 1);
          we_n_d  = rd_q;
          re_n_d  = ~rd_q;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      CYC_STROBE: begin
        if (cnt_q == '0) begin
          phase_d = CYC_HOLD;
          we_n_d  = 1'b1;
          re_n_d  = 1'b1;
          if (rd_q) begin
            rbyte_d = dq_in;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: phase_d = CYC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= CYC_IDLE;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      dq_q    <= '0;
      oe_q    <= 1'b0;
      we_n_q  <= 1'b1;
      re_n_q  <= 1'b1;
      rbyte_q <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      rd_q    <= rd_d;
      dq_q    <= dq_d;
      oe_q    <= oe_d;
      we_n_q  <= we_n_d;
      re_n_q  <= re_n_d;
      rbyte_q <= rbyte_d;
    end
  end

  assign last   = (phase_q == CYC_HOLD);
  assign rbyte  = rbyte_q;
  assign we_n   = we_n_q;
  assign re_n   = re_n_q;
  assign dq_out = dq_q;
  assign dq_oe  = oe_q;

  assert_strobe_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n_q && !re_n_q));

  assert_setup_before_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n_q) |-> (oe_q && $past(oe_q)));

  assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n_q |-> !oe_q);

endmodule

// File: rtl/nand_host_bridge.sv
module nand_host_bridge
  import nhb_pkg::*;
#(
  parameter int unsigned HOST_W      = 16,
  parameter int unsigned SETUP_CLKS  = 1,
  parameter int unsigned STROBE_CLKS = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hb_req,
  input  logic              hb_wr,
  input  logic              hb_wide,
  input  logic [2:0]        hb_addr,
  input  logic [HOST_W-1:0] hb_wdata,
  output logic [HOST_W-1:0] hb_rdata,
  output logic              hb_ack,
  output logic              nf_ce_n,
  output logic              nf_cle,
  output logic              nf_ale,
  output logic              nf_we_n,
  output logic              nf_re_n,
  output logic [7:0]        nf_dq_out,
  output logic              nf_dq_oe,
  input  logic [7:0]        nf_dq_in,
  input  logic              nf_rb_n,
  output logic              irq
);

  localparam int unsigned LANES  = HOST_W / 8;
  localparam int unsigned LANE_W = $clog2(LANES);

  host_state_e       st_q, st_d;
  logic [7:0]        mode_q, mode_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic [LANE_W-1:0] last_lane_q, last_lane_d;
  logic              rd_q, rd_d;
  logic [HOST_W-1:0] rdata_q, rdata_d;
  logic              ack_q, ack_d;

  logic              accept, is_data, more;
  logic              seq_start, seq_last, seq_rd;
  logic [LANE_W-1:0] lane_sel;
  logic [7:0]        seq_wbyte, seq_rbyte;
  logic [7:0]        reg_rd;
  logic              rb_ready, rb_rise;
  logic              pend_clr, mask_we;
  logic              pend;
  logic [7:0]        mask;

  nhb_rb_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rb_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rb_n_async (nf_rb_n),
    .rb_ready   (rb_ready),
    .rb_rise    (rb_rise)
  );

  nhb_irq_ctrl u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready_evt  (rb_rise),
    .pend_clr   (pend_clr),
    .mask_we    (mask_we),
    .mask_wdata (hb_wdata[7:0]),
    .pend       (pend),
    .mask       (mask),
    .irq        (irq)
  );

  nhb_byte_cycle #(.SETUP_CLKS(SETUP_CLKS), .STROBE_CLKS(STROBE_CLKS)) u_cycle (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (seq_start),
    .rd     (seq_rd),
    .wbyte  (seq_wbyte),
    .dq_in  (nf_dq_in),
    .last   (seq_last),
    .rbyte  (seq_rbyte),
    .we_n   (nf_we_n),
    .re_n   (nf_re_n),
    .dq_out (nf_dq_out),
    .dq_oe  (nf_dq_oe)
  );

  // request decode and byte sequencing
  always_comb begin
    accept    = (st_q == HOST_IDLE) && hb_req;
    is_data   = (hb_addr == OFS_DATA);
    more      = (lane_q != last_lane_q);
    seq_start = (accept && is_data) || ((st_q == HOST_XFER) && seq_last && more);
    seq_rd    = accept ? ~hb_wr : rd_q;
    lane_sel  = accept ? '0 : (lane_q + LANE_W'(1));
    seq_wbyte = hb_wdata[{lane_sel, 3'b000} +: 8];
    pend_clr  = accept && hb_wr && (hb_addr == OFS_IRQ_PEND) && hb_wdata[0];
    mask_we   = accept && hb_wr && (hb_addr == OFS_IRQ_MASK);
  end

  // register read mux
  always_comb begin
    case (hb_addr)
      OFS_MODE:     reg_rd = mode_q;
      OFS_STAT:     reg_rd = {~rb_ready, 7'b0};
      OFS_IRQ_PEND: reg_rd = {7'b0, pend};
      OFS_IRQ_MASK: reg_rd = mask;
      default:      reg_rd = 8'h00;
    endcase
  end

  always_comb begin
    st_d        = st_q;
    mode_d      = mode_q;
    lane_d      = lane_q;
    last_lane_d = last_lane_q;
    rd_d        = rd_q;
    rdata_d     = rdata_q;
    ack_d       = 1'b0;
    if (accept) begin
      if (is_data) begin
        st_d        = HOST_XFER;
        lane_d      = '0;
        last_lane_d = hb_wide ? LANE_W'(LANES - 1) : '0;
        rd_d        = ~hb_wr;
        if (!hb_wr) begin
          rdata_d = '0;
        end
      end else begin
        ack_d   = 1'b1;
        rdata_d = {{(HOST_W-8){1'b0}}, reg_rd};
        if (hb_wr && (hb_addr == OFS_MODE)) begin
          mode_d = hb_wdata[7:0];
        end
      end
    end else if ((st_q == HOST_XFER) && seq_last) begin
      if (rd_q) begin
        rdata_d[{lane_q, 3'b000} +: 8] = seq_rbyte;
      end
      if (more) begin
        lane_d = lane_q + LANE_W'(1);
      end else begin
        st_d  = HOST_IDLE;
        ack_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= HOST_IDLE;
      mode_q      <= '0;
      lane_q      <= '0;
      last_lane_q <= '0;
      rd_q        <= 1'b0;
      rdata_q     <= '0;
      ack_q       <= 1'b0;
    end else begin
      st_q        <= st_d;
      mode_q      <= mode_d;
      lane_q      <= lane_d;
      last_lane_q <= last_lane_d;
      rd_q        <= rd_d;
      rdata_q     <= rdata_d;
      ack_q       <= ack_d;
    end
  end

  assign hb_rdata = rdata_q;
  assign hb_ack   = ack_q;
  assign nf_ce_n  = ~mode_q[MODE_CE];
  assign nf_cle   = mode_q[MODE_CLE];
  assign nf_ale   = mode_q[MODE_ALE];

  assert_no_ack_mid_xfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == HOST_XFER) |-> !hb_ack);

  assert_idle_strobes_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == HOST_IDLE) |-> (nf_we_n && nf_re_n));

endmodule

// File: tb/test_nand_host_bridge.sv
module test_nand_host_bridge;

  localparam int HOST_W = 16;
  localparam int SETUP  = 2;
  localparam int STROBE = 3;
  localparam int BYTE_T = SETUP + STROBE + 1;

  logic              clk;
  logic              rst_n;
  logic              hb_req, hb_wr, hb_wide;
  logic [2:0]        hb_addr;
  logic [HOST_W-1:0] hb_wdata;
  logic [HOST_W-1:0] hb_rdata;
  logic              hb_ack;
  logic              nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
  logic [7:0]        nf_dq_out, nf_dq_in;
  logic              nf_rb_n;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  nand_host_bridge #(
    .HOST_W(HOST_W), .SETUP_CLKS(SETUP), .STROBE_CLKS(STROBE), .SYNC_STAGES(2)
  ) i_nand_host_bridge (
    .clk(clk), .rst_n(rst_n), .hb_req(hb_req), .hb_wr(hb_wr), .hb_wide(hb_wide),
    .hb_addr(hb_addr), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .hb_ack(hb_ack),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
    .nf_re_n(nf_re_n), .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe),
    .nf_dq_in(nf_dq_in), .nf_rb_n(nf_rb_n), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model, updated every clock ----------------
  logic [7:0] m_mode, m_mask;
  logic       m_pend, m_irq, m_busy;
  logic [2:0] rbh;
  bit         chk_en = 0;

  always @(posedge clk) begin
    logic evt, clr, nirq;
    if (!rst_n) begin
      m_mode = 8'h00; m_mask = 8'h00; m_pend = 1'b0; m_irq = 1'b0;
      m_busy = 1'b0;  rbh = 3'b111;   chk_en = 0;
    end else begin
      evt  = rbh[1] & ~rbh[2];
      nirq = m_mask[7] & m_mask[0] & m_pend;
      clr  = 1'b0;
      if (hb_req && !m_busy) begin
        if (hb_addr == 3'h0) m_busy = 1'b1;
        else if (hb_wr) begin
          if (hb_addr == 3'h4) m_mode = hb_wdata[7:0];
          if (hb_addr == 3'h6) clr = hb_wdata[0];
          if (hb_addr == 3'h7) m_mask = hb_wdata[7:0];
        end
      end else if (!hb_req) begin
        m_busy = 1'b0;
      end
      m_pend = evt | (m_pend & ~clr);
      m_irq  = nirq;
      rbh    = {rbh[1:0], nf_rb_n};
      chk_en = 1;
    end
  end

  always @(negedge clk) begin
    if (chk_en && !done) begin
      check(irq === m_irq, "R10", "irq vs model", irq, m_irq);
      check({nf_ce_n, nf_cle, nf_ale} === {~m_mode[4], m_mode[0], m_mode[1]},
            "R2", "ce_n/cle/ale vs model", {nf_ce_n, nf_cle, nf_ale},
            {~m_mode[4], m_mode[0], m_mode[1]});
    end
  end

  // ---------------- flash device model ----------------
  logic [9:0] wlog[$];
  logic [7:0] rsrc[$];

  always @(posedge nf_we_n) begin
    if (rst_n === 1'b1) wlog.push_back({nf_cle, nf_ale, nf_dq_out});
  end

  always @(negedge nf_re_n) begin
    if (rst_n === 1'b1) nf_dq_in = (rsrc.size() > 0) ? rsrc.pop_front() : 8'h00;
  end

  // strobe width / set-up monitor
  int  we_run = 0, re_run = 0, strobes_seen = 0;
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (chk_en && !done) begin
      if (!nf_we_n) begin
        if (we_run == 0) check(prev_oe === 1'b1, "R6", "data driven before WE#", prev_oe, 1);
        we_run++;
      end else if (we_run > 0) begin
        check(we_run == STROBE, "R6", "WE# low width", we_run, STROBE);
        we_run = 0; strobes_seen++;
      end
      if (!nf_re_n) begin
        if (nf_dq_oe !== 1'b0) check(0, "R6", "bus driven during RE#", nf_dq_oe, 0);
        re_run++;
      end else if (re_run > 0) begin
        check(re_run == STROBE, "R6", "RE# low width", re_run, STROBE);
        re_run = 0; strobes_seen++;
      end
      if (!nf_we_n && !nf_re_n) check(0, "R6", "both strobes low", 1, 0);
      prev_oe = nf_dq_oe;
    end
  end

  // ---------------- host tasks ----------------
  task automatic bus(input bit wr, input bit wide, input logic [2:0] addr,
                     input logic [15:0] wd, output logic [15:0] rd, output int lat);
    @(negedge clk);
    hb_req = 1'b1; hb_wr = wr; hb_wide = wide; hb_addr = addr; hb_wdata = wd;
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
    end while (!hb_ack && lat < 1000);
    rd = hb_rdata;
    hb_req = 1'b0;
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [15:0] rd;
    logic [9:0]  b0, b1;
    int lat;
    rst_n = 1'b0; hb_req = 0; hb_wr = 0; hb_wide = 0; hb_addr = 0; hb_wdata = 0;
    nf_rb_n = 1'b1; nf_dq_in = 8'h00;
    wclk(3);
    check({nf_ce_n, nf_cle, nf_ale} === 3'b100, "R1", "latch pins in reset",
          {nf_ce_n, nf_cle, nf_ale}, 3'b100);
    check({nf_we_n, nf_re_n, nf_dq_oe} === 3'b110, "R1", "strobes/oe in reset",
          {nf_we_n, nf_re_n, nf_dq_oe}, 3'b110);
    check({irq, hb_ack} === 2'b00, "R1", "irq/ack in reset", {irq, hb_ack}, 0);
    rst_n = 1'b1;
    wclk(2);

    // R2 command mode, readback, register latency R7
    bus(1, 0, 3'h4, 16'h0095, rd, lat);
    check(lat == 1, "R7", "register ack latency", lat, 1);
    bus(0, 0, 3'h4, 16'h0, rd, lat);
    check(rd === 16'h0095, "R2", "mode readback", rd, 16'h0095);
    check(nf_ce_n === 1'b0 && nf_cle === 1'b1, "R2", "command mode pins",
          {nf_ce_n, nf_cle}, 2'b01);

    // R3 single command byte
    bus(1, 0, 3'h0, 16'h00FF, rd, lat);
    check(lat == BYTE_T + 1, "R7", "8-bit write ack latency", lat, BYTE_T + 1);
    check(wlog.size() == 1, "R3", "one write cycle", wlog.size(), 1);
    b0 = (wlog.size() > 0) ? wlog.pop_front() : 10'h3FF;
    check(b0 === {2'b10, 8'hFF}, "R3", "command byte cle/ale/data", b0, {2'b10, 8'hFF});

    // R3 address byte, upper bits unused
    bus(1, 0, 3'h4, 16'h0096, rd, lat);
    bus(1, 0, 3'h0, 16'h1230, rd, lat);
    check(wlog.size() == 1, "R3", "one address cycle", wlog.size(), 1);
    b0 = (wlog.size() > 0) ? wlog.pop_front() : 10'h3FF;
    check(b0 === {2'b01, 8'h30}, "R3", "address byte cle/ale/data", b0, {2'b01, 8'h30});

    // R4 16-bit write order
    bus(1, 0, 3'h4, 16'h0094, rd, lat);
    bus(1, 1, 3'h0, 16'hBEEF, rd, lat);
    check(lat == 2 * BYTE_T + 1, "R7", "16-bit write ack latency", lat, 2 * BYTE_T + 1);
    check(wlog.size() == 2, "R4", "two write cycles", wlog.size(), 2);
    b0 = (wlog.size() > 0) ? wlog.pop_front() : 10'h3FF;
    b1 = (wlog.size() > 0) ? wlog.pop_front() : 10'h3FF;
    check(b0 === {2'b00, 8'hEF}, "R4", "first byte is low half", b0, {2'b00, 8'hEF});
    check(b1 === {2'b00, 8'hBE}, "R4", "second byte is high half", b1, {2'b00, 8'hBE});

    // R5 reads
    rsrc.push_back(8'hA5); rsrc.push_back(8'h3C);
    bus(0, 1, 3'h0, 16'h0, rd, lat);
    check(rd === 16'h3CA5, "R5", "16-bit read packing", rd, 16'h3CA5);
    check(lat == 2 * BYTE_T + 1, "R7", "16-bit read ack latency", lat, 2 * BYTE_T + 1);
    rsrc.push_back(8'h77);
    bus(0, 0, 3'h0, 16'h0, rd, lat);
    check(rd === 16'h0077, "R5", "8-bit read zero upper", rd, 16'h0077);
    check(wlog.size() == 0, "R5", "reads produce no write strobes", wlog.size(), 0);

    // standby
    bus(1, 0, 3'h4, 16'h0000, rd, lat);
    check(nf_ce_n === 1'b1, "R2", "standby releases CE#", nf_ce_n, 1);

    // R8 busy status
    nf_rb_n = 1'b0; wclk(4);
    bus(0, 0, 3'h5, 16'h0, rd, lat);
    check(rd === 16'h0080, "R8", "status busy", rd, 16'h0080);
    nf_rb_n = 1'b1; wclk(4);
    bus(0, 0, 3'h5, 16'h0, rd, lat);
    check(rd === 16'h0000, "R8", "status ready", rd, 16'h0000);

    // R9 pending latched, R10 masked
    bus(0, 0, 3'h6, 16'h0, rd, lat);
    check(rd === 16'h0001, "R9", "ready event pending", rd, 16'h0001);
    check(irq === 1'b0, "R10", "irq masked with mask 0", irq, 0);
    bus(1, 0, 3'h7, 16'h0001, rd, lat); wclk(2);
    check(irq === 1'b0, "R10", "irq needs global bit", irq, 0);
    bus(1, 0, 3'h7, 16'h0081, rd, lat); wclk(2);
    check(irq === 1'b1, "R10", "irq enabled by 0x81", irq, 1);
    bus(0, 0, 3'h7, 16'h0, rd, lat);
    check(rd === 16'h0081, "R10", "mask readback", rd, 16'h0081);
    bus(1, 0, 3'h6, 16'h000F, rd, lat); wclk(2);
    bus(0, 0, 3'h6, 16'h0, rd, lat);
    check(rd === 16'h0000, "R9", "pending cleared by 0x0F", rd, 16'h0000);
    check(irq === 1'b0, "R9", "irq drops after clear", irq, 0);

    // second busy release with interrupt enabled
    nf_rb_n = 1'b0; wclk(4); nf_rb_n = 1'b1; wclk(6);
    check(irq === 1'b1, "R9", "new release raises irq", irq, 1);

    check(strobes_seen == 7, "R6", "strobe count", strobes_seen, 7);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule